// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This block is the processor-side logic that takes exceptions and returns from them. Each cycle it looks at four kinds of request: a synchronous exception, which carries a syndrome word, a system-error request, a fast-interrupt request and an ordinary interrupt request. It picks at most one of them. The three asynchronous kinds are each gated by their own mask bit in the incoming status word. When a request is taken, the unit saves the current PC into a link register and the whole status word into a saved-status register. It then produces a redirect PC inside a vector table and an updated status word. The updated word has every mask bit set and selects the exception stack.

The vector table sits at a base register whose low 11 bits are always zero, giving 2 KB alignment. The table holds 16 slots, each 0x80 bytes. The slot is chosen by where the exception came from and by what kind it is. An exception-return strobe does the reverse: it redirects to the link register and restores the saved status word. The instruction pipeline and the stack pointers are outside this block. Only the stack-select bit inside the status word is modelled.

Status word layout used throughout:
- bit 0: stack select (SPSEL)
- bits [3:2]: level
- bit 4: 32-bit execution state
- bit 6: F mask (fast interrupt)
- bit 7: I mask (interrupt)
- bit 8: A mask (system error)
- bit 9: D mask (debug)
- bit 20: illegal-state flag
- all other bits: carried through unchanged

Top module: `exc_entry_unit`

## Requirements
- R1: The interrupt request is taken only while `irq_req` is 1 and status bit 7 (I) is 0. While I is 1 the request has no effect, and it is taken on the first cycle after I clears if `irq_req` is still high.
- R2: On entry, `elr_q` receives `cur_pc` and `spsr_q` receives the full `cur_status`, both on the same clock edge.
- R3: On entry, `new_status` is `cur_status` with the following changes: bits 9, 8, 7 and 6 (D, A, I, F) set to 1; bit 20 (illegal state) cleared; bit 0 (stack select) set to 1; bits [3:2] (level) set to 1; bit 4 (32-bit state) cleared. All other bits are unchanged.
- R4: On entry, `redirect_pc` equals `vbar_q` plus a group offset plus a kind offset. The kind offsets are 0x000 for synchronous, 0x080 for interrupt, 0x100 for fast interrupt and 0x180 for system error. With base 0x4000_0800, an interrupt from level 0 in 64-bit state lands at 0x4000_0C80, and one from level 1 with stack select 1 lands at 0x4000_0A80.
- R5: The group offset depends on the status word. Level 0 in 64-bit state (bit 4 = 0) gives 0x400. Level 0 in 32-bit state gives 0x600. Any nonzero level with stack select 0 gives 0x000. Any nonzero level with stack select 1 gives 0x200.
- R6: When several requests are present, the synchronous one wins, then system error (gated by bit 8), then fast interrupt (gated by bit 6), then interrupt (gated by bit 7). The synchronous request has no mask.
- R7: An `eret_strobe` that is accepted pulses `redirect_valid` with `redirect_pc` equal to the `elr_q` value before the edge and `new_status` equal to the `spsr_q` value before the edge.
- R8: A synchronous entry loads `esr_q` with `sync_syndrome`: class in bits [31:26], instruction-length flag in bit 25, detail in bits [24:0]. Asynchronous entries leave `esr_q` unchanged.
- R9: `level_view` presents the level from `cur_status[3:2]` in its bits [3:2], with bits [1:0] reading 0.
- R10: A write through `vbar_we` stores `vbar_wdata` with bits [10:0] forced to zero. An entry in the same cycle uses the old base.
- R11: `redirect_valid` is a one-cycle pulse in the cycle after the accepted request. Any request or return strobe present during that pulse cycle is not sampled.
- R12: After reset, `redirect_valid` is 0 and `elr_q`, `spsr_q`, `esr_q` and `vbar_q` are 0.
- R13: If an exception is taken in the same cycle as `eret_strobe`, the exception wins and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Interrupt request level |
| fiq_req | input | 1 | Fast interrupt request level |
| serr_req | input | 1 | System error request level |
| sync_req | input | 1 | Synchronous exception request |
| sync_syndrome | input | 32 | Syndrome word of the synchronous exception |
| eret_strobe | input | 1 | Exception-return strobe |
| cur_pc | input | PC_W | PC of the interrupted context |
| cur_status | input | 32 | Current status word |
| vbar_we | input | 1 | Vector base write enable |
| vbar_wdata | input | PC_W | Vector base write data |
| redirect_valid | output | 1 | One-cycle pulse: redirect the fetch |
| redirect_pc | output | PC_W | Target PC for the redirect |
| new_status | output | 32 | Status word to install with the redirect |
| elr_q | output | PC_W | Link register |
| spsr_q | output | 32 | Saved status register |
| esr_q | output | 32 | Syndrome register |
| vbar_q | output | PC_W | Vector base register |
| level_view | output | 4 | Read-only current-level view |

## Verification
Random request mixes, with random mask bits, levels, stack-select values and execution states, are compared against a bench model. This separates errors in priority from errors in masking, because a masked winner must give way to the next kind down the order. Directed cases cover several specific situations:
- a held interrupt under the I mask, which shows that the request stays pending rather than being lost;
- fixed-address landings for two origins, which separate the group offset from the kind offset;
- a return strobe alone and a return strobe together with an interrupt, which tell the return path apart from the exception path that overrides it;
- back-to-back held requests, which expose whether the pulse cycle wrongly samples new requests.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int ST_W       = 32;
  localparam int SB_SPSEL   = 0;
  localparam int SB_LVL_LO  = 2;
  localparam int SB_EXEC32  = 4;
  localparam int SB_F       = 6;
  localparam int SB_I       = 7;
  localparam int SB_A       = 8;
  localparam int SB_D       = 9;
  localparam int SB_IL      = 20;
  localparam int ALIGN_BITS = 11;
  localparam int SLOT_SHIFT = 7;
  localparam int LVL_W      = 2;
  localparam int SYN_W      = 32;

  typedef enum logic [1:0] {
    K_SYNC = 2'd0,
    K_IRQ  = 2'd1,
    K_FIQ  = 2'd2,
    K_SERR = 2'd3
  } exc_kind_e;

  typedef logic [ST_W-1:0] status_t;

  function automatic logic [LVL_W-1:0] status_level(status_t st);
    return st[SB_LVL_LO +: LVL_W];
  endfunction

  // Origin group: lower level splits on execution state, current level on stack select
  function automatic logic [ALIGN_BITS-1:0] group_offset(status_t st);
    logic [ALIGN_BITS-1:0] g;
    if (status_level(st) == '0)
      g = st[SB_EXEC32] ? 11'h600 : 11'h400;
    else
      g = st[SB_SPSEL] ? 11'h200 : 11'h000;
    return g;
  endfunction

  function automatic logic [ALIGN_BITS-1:0] slot_offset(exc_kind_e k);
    logic [ALIGN_BITS-1:0] s;
    s = '0;
    s[SLOT_SHIFT +: 2] = k;
    return s;
  endfunction

  function automatic status_t entry_status(status_t st);
    status_t s;
    s = st;
    s[SB_D]      = 1'b1;
    s[SB_A]      = 1'b1;
    s[SB_I]      = 1'b1;
    s[SB_F]      = 1'b1;
    s[SB_IL]     = 1'b0;
    s[SB_SPSEL]  = 1'b1;
    s[SB_EXEC32] = 1'b0;
    s[SB_LVL_LO +: LVL_W] = 2'd1;
    return s;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      sync_req,
  input  logic      serr_req,
  input  logic      fiq_req,
  input  logic      irq_req,
  input  status_t   status,
  output logic      pick_valid,
  output exc_kind_e pick_kind
);
  logic serr_ok, fiq_ok, irq_ok;

  assign serr_ok = serr_req && !status[SB_A];
  assign fiq_ok  = fiq_req  && !status[SB_F];
  assign irq_ok  = irq_req  && !status[SB_I];

  always_comb begin
    pick_valid = 1'b1;
    pick_kind  = K_SYNC;
    if (sync_req)     pick_kind = K_SYNC;
    else if (serr_ok) pick_kind = K_SERR;
    else if (fiq_ok)  pick_kind = K_FIQ;
    else if (irq_ok)  pick_kind = K_IRQ;
    else              pick_valid = 1'b0;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic [PC_W-1:0] base,
  input  status_t         status,
  input  exc_kind_e       kind,
  output logic [PC_W-1:0] target
);
  logic [ALIGN_BITS-1:0] low_part;

  // group occupies [10:9], slot [8:7]: disjoint, so OR equals add
  assign low_part = group_offset(status) | slot_offset(kind);
  assign target   = {base[PC_W-1:ALIGN_BITS], low_part};
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic              serr_req,
  input  logic              sync_req,
  input  logic [SYN_W-1:0]  sync_syndrome,
  input  logic              eret_strobe,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [ST_W-1:0]   cur_status,
  input  logic              vbar_we,
  input  logic [PC_W-1:0]   vbar_wdata,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   redirect_pc,
  output logic [ST_W-1:0]   new_status,
  output logic [PC_W-1:0]   elr_q,
  output logic [ST_W-1:0]   spsr_q,
  output logic [SYN_W-1:0]  esr_q,
  output logic [PC_W-1:0]   vbar_q,
  output logic [3:0]        level_view
);
  localparam logic [PC_W-1:0] ALIGN_MASK = {{(PC_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic            pick_valid;
  exc_kind_e       pick_kind;
  logic [PC_W-1:0] vec_target;
  logic            take_valid;
  exc_kind_e       take_kind;
  logic            eret_go;

  exc_arbiter u_arb (
    .sync_req   (sync_req),
    .serr_req   (serr_req),
    .fiq_req    (fiq_req),
    .irq_req    (irq_req),
    .status     (cur_status),
    .pick_valid (pick_valid),
    .pick_kind  (pick_kind)
  );

  exc_vector_gen #(.PC_W(PC_W)) u_vec (
    .base   (vbar_q),
    .status (cur_status),
    .kind   (pick_kind),
    .target (vec_target)
  );

  // requests are not sampled in the redirect cycle
  assign take_valid = pick_valid && !redirect_valid;
  assign take_kind  = pick_kind;
  assign eret_go    = eret_strobe && !redirect_valid && !pick_valid;

  assign level_view = {status_level(cur_status), 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      new_status     <= '0;
      elr_q          <= '0;
      spsr_q         <= '0;
      esr_q          <= '0;
    end else if (take_valid) begin
      redirect_valid <= 1'b1;
      redirect_pc    <= vec_target;
      new_status     <= entry_status(cur_status);
      elr_q          <= cur_pc;
      spsr_q         <= cur_status;
      if (take_kind == K_SYNC) esr_q <= sync_syndrome;
    end else if (eret_go) begin
      redirect_valid <= 1'b1;
      redirect_pc    <= elr_q;
      new_status     <= spsr_q;
    end else begin
      redirect_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vbar_q <= '0;
    else if (vbar_we) vbar_q <= vbar_wdata & ALIGN_MASK;
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
  import exc_pkg::*;
#(
  parameter int PC_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic             sync_req,
  input logic             eret_strobe,
  input logic [PC_W-1:0]  cur_pc,
  input logic [ST_W-1:0]  cur_status,
  input logic             vbar_we,
  input logic [PC_W-1:0]  vbar_wdata,
  input logic             redirect_valid,
  input logic [PC_W-1:0]  redirect_pc,
  input logic [ST_W-1:0]  new_status,
  input logic [PC_W-1:0]  elr_q,
  input logic [ST_W-1:0]  spsr_q,
  input logic [SYN_W-1:0] esr_q,
  input logic [PC_W-1:0]  vbar_q,
  input logic             take_valid,
  input exc_kind_e        take_kind,
  input logic             eret_go
);
  assert_irq_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_kind == K_IRQ) |-> (irq_req && !cur_status[SB_I]));

  assert_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |=> (elr_q == $past(cur_pc) && spsr_q == $past(cur_status)));

  assert_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |=> (redirect_valid && new_status[SB_D] && new_status[SB_A] &&
                    new_status[SB_I] && new_status[SB_F] && !new_status[SB_IL] &&
                    new_status[SB_SPSEL]));

  assert_sync_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && !redirect_valid) |-> (take_valid && take_kind == K_SYNC));

  assert_eret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eret_go |=> (redirect_valid && redirect_pc == $past(elr_q) &&
                 new_status == $past(spsr_q)));

  assert_async_keeps_esr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_kind != K_SYNC) |=> $stable(esr_q));

  assert_base_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vbar_we |=> (vbar_q[PC_W-1:ALIGN_BITS] == $past(vbar_wdata[PC_W-1:ALIGN_BITS]) &&
                 vbar_q[ALIGN_BITS-1:0] == '0));

  assert_no_sample_in_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (!take_valid && !eret_go));

  assert_exception_beats_return_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_strobe && take_valid) |-> !eret_go);
endmodule

bind exc_entry_unit exc_entry_checker #(.PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_req        (irq_req),
  .sync_req       (sync_req),
  .eret_strobe    (eret_strobe),
  .cur_pc         (cur_pc),
  .cur_status     (cur_status),
  .vbar_we        (vbar_we),
  .vbar_wdata     (vbar_wdata),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .new_status     (new_status),
  .elr_q          (elr_q),
  .spsr_q         (spsr_q),
  .esr_q          (esr_q),
  .vbar_q         (vbar_q),
  .take_valid     (take_valid),
  .take_kind      (take_kind),
  .eret_go        (eret_go)
);

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;
  localparam int PC_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, fiq_req = 0, serr_req = 0, sync_req = 0, eret_strobe = 0, vbar_we = 0;
  logic [31:0] sync_syndrome = '0;
  logic [PC_W-1:0] cur_pc = '0, vbar_wdata = '0;
  logic [31:0] cur_status = '0;
  logic redirect_valid;
  logic [PC_W-1:0] redirect_pc, elr_q, vbar_q;
  logic [31:0] new_status, spsr_q, esr_q;
  logic [3:0] level_view;

  int n_checks = 0;
  int n_fail = 0;

  logic            m_rv;
  logic [PC_W-1:0] m_pc, m_elr, m_vbar;
  logic [31:0]     m_st, m_spsr, m_esr;

  always #2.5 clk = ~clk;

  exc_entry_unit #(.PC_W(PC_W)) u_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fiq_req(fiq_req),
    .serr_req(serr_req), .sync_req(sync_req), .sync_syndrome(sync_syndrome),
    .eret_strobe(eret_strobe), .cur_pc(cur_pc), .cur_status(cur_status),
    .vbar_we(vbar_we), .vbar_wdata(vbar_wdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .new_status(new_status), .elr_q(elr_q),
    .spsr_q(spsr_q), .esr_q(esr_q), .vbar_q(vbar_q), .level_view(level_view)
  );

  task automatic check(input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // 0 sync, 1 irq, 2 fiq, 3 serr
  function automatic logic [PC_W-1:0] exp_vector(logic [PC_W-1:0] base, logic [31:0] st, int kind);
    logic [PC_W-1:0] grp;
    if (st[3:2] != 2'b00) grp = st[0] ? 64'h200 : 64'h0;
    else                  grp = st[4] ? 64'h600 : 64'h400;
    return (base & ~64'h7FF) + grp + 64'(kind) * 64'h80;
  endfunction

  function automatic logic [31:0] exp_entry(logic [31:0] st);
    logic [31:0] s;
    s = st | 32'h0000_03C1;
    s = s & ~(32'h0010_0000 | 32'h0000_0010 | 32'h0000_000C);
    return s | 32'h0000_0004;
  endfunction

  task automatic tick();
    int kind;
    logic take;
    take = 1'b0;
    kind = 0;
    if (!m_rv) begin
      if (sync_req)                        begin take = 1; kind = 0; end
      else if (serr_req && !cur_status[8]) begin take = 1; kind = 3; end
      else if (fiq_req && !cur_status[6])  begin take = 1; kind = 2; end
      else if (irq_req && !cur_status[7])  begin take = 1; kind = 1; end
    end
    if (take) begin
      m_rv = 1; m_pc = exp_vector(m_vbar, cur_status, kind); m_st = exp_entry(cur_status);
      m_elr = cur_pc; m_spsr = cur_status;
      if (kind == 0) m_esr = sync_syndrome;
    end else if (!m_rv && eret_strobe) begin
      m_rv = 1; m_pc = m_elr; m_st = m_spsr;
    end else begin
      m_rv = 0;
    end
    if (vbar_we) m_vbar = vbar_wdata & ~64'h7FF;
    @(posedge clk); #1;
    check("R11 redirect pulse", 64'(redirect_valid), 64'(m_rv));
    if (m_rv) begin
      check("R4 R7 redirect pc", redirect_pc, m_pc);
      check("R3 R7 new status", 64'(new_status), 64'(m_st));
    end
    check("R2 link", elr_q, m_elr);
    check("R2 saved status", 64'(spsr_q), 64'(m_spsr));
    check("R8 syndrome", 64'(esr_q), 64'(m_esr));
    check("R10 base", vbar_q, m_vbar);
    check("R9 level view", 64'(level_view), 64'({cur_status[3:2], 2'b00}));
  endtask

  task automatic idle();
    irq_req = 0; fiq_req = 0; serr_req = 0; sync_req = 0; eret_strobe = 0; vbar_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h00C0_FFEE);
    m_rv = 0; m_pc = '0; m_st = '0; m_elr = '0; m_spsr = '0; m_esr = '0; m_vbar = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    check("R12 valid", 64'(redirect_valid), 64'd0);
    check("R12 link", elr_q, '0);
    check("R12 saved", 64'(spsr_q), 64'd0);
    check("R12 syndrome", 64'(esr_q), 64'd0);
    check("R12 base", vbar_q, '0);

    // R10 unaligned base write
    vbar_we = 1; vbar_wdata = 64'h4000_0FFF; tick(); idle();
    check("R10 aligned base", vbar_q, 64'h4000_0800);

    // R4 R5 interrupt from level 0, 64-bit
    cur_status = 32'h0; cur_pc = 64'h1234; irq_req = 1; tick();
    check("R4 level0 landing", redirect_pc, 64'h4000_0C80);
    // R11 held request in pulse cycle is not sampled
    tick();
    check("R11 no retake", 64'(redirect_valid), 64'd0);
    // R4 level 1, stack select 1
    cur_status = 32'h5; tick();
    check("R4 level1 sp1 landing", redirect_pc, 64'h4000_0A80);
    idle(); tick();

    // R1 masked interrupt stays pending
    cur_status = 32'h84; irq_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R1 masked ignored", 64'(redirect_valid), 64'd0);
    end
    cur_status = 32'h4; tick();
    check("R1 taken after unmask", 64'(redirect_valid), 64'd1);
    idle(); tick();

    // R6 R8 all requests together
    cur_status = 32'h4; sync_req = 1; serr_req = 1; fiq_req = 1; irq_req = 1;
    sync_syndrome = 32'h5600_0ABC; tick();
    check("R6 sync wins", redirect_pc, 64'h4000_0800);
    check("R8 syndrome load", 64'(esr_q), 64'h5600_0ABC);
    sync_req = 0; tick(); tick();
    check("R6 serr next", redirect_pc, 64'h4000_0980);
    tick(); cur_status = 32'h104; tick();
    check("R6 fiq when A masked", redirect_pc, 64'h4000_0900);
    check("R8 async keeps syndrome", 64'(esr_q), 64'h5600_0ABC);
    idle(); tick();

    // R7 return
    eret_strobe = 1; tick();
    check("R7 return pc", redirect_pc, m_elr);
    idle(); tick();
    // R13 exception beats return
    cur_status = 32'h4; eret_strobe = 1; irq_req = 1; tick();
    check("R13 exception wins", redirect_pc, 64'h4000_0880);
    idle(); tick();
    // R9 level view
    cur_status = 32'h8; tick();
    check("R9 level two", 64'(level_view), 64'h8);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      sync_req      = ($urandom % 16) == 0;
      serr_req      = ($urandom % 12) == 0;
      fiq_req       = ($urandom % 8) == 0;
      irq_req       = ($urandom % 3) == 0;
      eret_strobe   = ($urandom % 6) == 0;
      vbar_we       = ($urandom % 20) == 0;
      vbar_wdata    = {$urandom, $urandom};
      sync_syndrome = $urandom;
      cur_status    = $urandom;
      cur_pc        = {$urandom, $urandom};
      tick();
    end
    idle(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule